// File: doc/BRIEF.md
# Page Permission and Translation Checker

This block turns one virtual address and an access kind into a physical address, a set of read, write and execute rights, and a 3-bit result code. It is purely combinational. It sits after a translation-buffer lookup that has already chosen an entry pair. It does not search the buffer and it does not raise exceptions. It reports only the outcome, and the pipeline around it uses that code to pick the fault to raise.

Three ways of translating are tried in a fixed order:

1. When direct addressing is on and paging is off, the address passes straight through.
2. Otherwise, four direct-map windows compare the top address bits against their base fields. Each window is gated by a per-privilege enable bit.
3. When no window claims the address, the address must be canonical. The block then uses the supplied even/odd entry pair: it selects one half by the page-size bit, checks it for faults in a fixed priority, and forms the frame address.

A clock and an active-low reset are present only to sample the embedded property checks. They have no effect on the outputs.

Top module: `page_xlat_checker`

## Requirements
- R1: When `direct_en` is 1 and `paging_en` is 0, `result` is 0 (match), `paddr` equals `vaddr[PA_W-1:0]` and all three rights are granted. This holds whatever the windows, `hit` or the upper address bits are.
- R2: Window w (bits [64w+63:64w] of `win_cfg`) matches when its bit [priv] (bits [3:0] hold one enable per privilege level) is 1 and its bits [63:48] equal `vaddr[63:48]`. A match gives result 0, all rights, and `paddr` equal to `vaddr` with bits 63:48 cleared and truncated to `PA_W`. It applies whenever R1 does not, whatever the value of `paging_en`.
- R3: With no window matching, if `vaddr[63:48]` is neither all zeros nor all ones, `result` is 1 (bad address), even when `hit` is 1.
- R4: A canonical address with no window match and `hit` at 0 gives result 2 (no match).
- R5: Bit [page_shift] of `vaddr` selects `entry_odd` when 1 and `entry_even` when 0. Only the selected word affects the outcome.
- R6: If bit 0 (valid) of the selected entry is 0, the result is 3 (invalid), ahead of every other entry check.
- R7: A fetch (`acc`=0) with bit 62 (no-execute) set gives result 6. This is checked before the read and privilege checks.
- R8: A load (`acc`=1) with bit 61 (no-read) set gives result 5. This is checked before the privilege check.
- R9: The entry level is bits [3:2] and the strict flag is bit 7. With strict at 0, `priv` numerically greater than the level gives result 7. With strict at 1, any difference gives result 7. This check comes before the dirty check.
- R10: A store (`acc`=2) to an entry whose bit 1 (dirty) is 0 gives result 4.
- R11: On a paged match, `paddr` = (entry bits [47:12] shifted left by 12) OR (`vaddr` AND (2^page_shift − 1)), truncated to `PA_W`.
- R12: On a paged match, read is granted, write equals the dirty bit, and execute equals the inverse of no-execute.
- R13: Whenever `result` is not 0, `paddr` is 0 and all three rights are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the embedded property checks only |
| rst_n | input | 1 | Active-low reset that disables the property checks |
| vaddr | input | 64 | Virtual address |
| acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| priv | input | 2 | Current privilege level, 0 most privileged |
| direct_en | input | 1 | Direct addressing mode bit |
| paging_en | input | 1 | Paging mode bit |
| win_cfg | input | 256 | Four window words: enables in [3:0], base in [63:48] |
| page_shift | input | 6 | Page-size exponent of the looked-up entry pair |
| hit | input | 1 | Lookup found an entry pair |
| entry_even | input | 64 | Even half of the entry pair |
| entry_odd | input | 64 | Odd half of the entry pair |
| paddr | output | 48 | Physical address |
| perm_r | output | 1 | Read right |
| perm_w | output | 1 | Write right |
| perm_x | output | 1 | Execute right |
| result | output | 3 | 0 match, 1 bad address, 2 no match, 3 invalid, 4 dirty, 5 read-inhibit, 6 execute-inhibit, 7 privilege |

## Verification
The properties assume that `acc` never takes the reserved value 3. They also assume that `page_shift` lies between 12 and 47, so the offset mask never reaches the frame field or the sign-extension bits. Every directed stimulus keeps to those ranges and changes inputs only at the falling clock edge, so each sampled cycle sees one stable input vector. The fault-order scenarios deliberately set several fault conditions in one entry, so that a wrong priority shows up as a different code rather than staying hidden.

// File: rtl/xlat_pkg.sv
// Package: shared encodings for the translation checker.
// Holds the result codes, access kinds and entry-word field positions.
// Assumes the entry word is 64 bits with the frame number starting at bit 12.
package xlat_pkg;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_BADADDR = 3'd1,
        RES_MISS    = 3'd2,
        RES_INVALID = 3'd3,
        RES_DIRTY   = 3'd4,
        RES_NOREAD  = 3'd5,
        RES_NOEXEC  = 3'd6,
        RES_PRIV    = 3'd7
    } xlat_res_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } xlat_acc_e;

    localparam int ENT_VALID  = 0;
    localparam int ENT_DIRTY  = 1;
    localparam int ENT_LVL_LO = 2;
    localparam int LVL_W      = 2;
    localparam int ENT_STRICT = 7;
    localparam int ENT_NOREAD = 61;
    localparam int ENT_NOEXEC = 62;
    localparam int FRAME_LSB  = 12;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic             strict;
        logic             no_read;
        logic             no_exec;
        logic [LVL_W-1:0] lvl;
    } ent_flags_t;

endpackage

// File: rtl/xlat_window_match.sv
// Module: xlat_window_match
// Decides whether one direct-map window claims the address.
// Assumes the enable bits for each privilege level sit at [NLVL-1:0]
// and the base field occupies the window word above VA_W.
module xlat_window_match #(
    parameter int XLEN = 64,
    parameter int VA_W = 48,
    parameter int NLVL = 4,
    localparam int UP_W  = XLEN - VA_W,
    localparam int PRV_W = $clog2(NLVL)
) (
    input  logic [XLEN-1:0]  win_word,
    input  logic [UP_W-1:0]  va_upper,
    input  logic [PRV_W-1:0] priv,
    output logic             match
);

    logic [NLVL-1:0] lvl_en;
    logic [UP_W-1:0] base;
    logic            unused_cfg;

    // Split the window word into its enable and base fields.
    always_comb begin
        lvl_en = win_word[NLVL-1:0];
        base   = win_word[XLEN-1:VA_W];
    end

    assign unused_cfg = ^win_word[VA_W-1:NLVL];

    // A window claims the address when enabled for this level and the bases agree.
    always_comb begin
        match = lvl_en[priv] && (base == va_upper);
    end

endmodule

// File: rtl/xlat_canon_check.sv
// Module: xlat_canon_check
// Flags whether the EXT_W bits above the virtual space width form a proper
// sign extension (all zeros or all ones).
// Assumes VA_W + EXT_W <= XLEN.
module xlat_canon_check #(
    parameter int XLEN  = 64,
    parameter int VA_W  = 48,
    parameter int EXT_W = 16
) (
    input  logic [XLEN-1:0] vaddr,
    output logic            canon_ok
);

    logic [EXT_W-1:0] ext;
    logic             unused_va;

    // Pick out the extension field.
    always_comb ext = vaddr[VA_W+EXT_W-1:VA_W];

    // Low bits play no part in the canonical test.
    assign unused_va = ^vaddr[VA_W-1:0];

    // Canonical when the extension is uniform.
    always_comb canon_ok = (ext == {EXT_W{1'b0}}) || (ext == {EXT_W{1'b1}});

endmodule

// File: rtl/xlat_page_check.sv
// Module: xlat_page_check
// Selects the even or odd half of a looked-up entry pair, runs the entry
// fault checks in fixed priority and forms the frame address and rights.
// Assumes a hit has already been established by the caller, acc is never
// the reserved code, and 12 <= page_shift < PA_W.
module xlat_page_check
    import xlat_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int PA_W = 48,
    localparam int SH_W = $clog2(XLEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  vaddr,
    input  logic [1:0]       acc,
    input  logic [LVL_W-1:0] priv,
    input  logic [SH_W-1:0]  page_shift,
    input  logic [XLEN-1:0]  entry_even,
    input  logic [XLEN-1:0]  entry_odd,
    output xlat_res_e        code,
    output logic [PA_W-1:0]  pa,
    output logic             r,
    output logic             w,
    output logic             x
);

    localparam int FRAME_W = PA_W - FRAME_LSB;

    logic [XLEN-1:0]    sel;
    ent_flags_t         fl;
    logic [XLEN-1:0]    off_mask;
    logic [FRAME_W-1:0] frame;
    logic               priv_bad;
    logic               unused_ent;

    // Choose the half of the pair named by the page-size bit.
    always_comb sel = vaddr[page_shift] ? entry_odd : entry_even;

    // Decode the flag fields of the chosen half.
    always_comb begin
        fl.valid   = sel[ENT_VALID];
        fl.dirty   = sel[ENT_DIRTY];
        fl.strict  = sel[ENT_STRICT];
        fl.no_read = sel[ENT_NOREAD];
        fl.no_exec = sel[ENT_NOEXEC];
        fl.lvl     = sel[ENT_LVL_LO +: LVL_W];
        frame      = sel[PA_W-1:FRAME_LSB];
    end

    assign unused_ent = ^{sel[XLEN-1:ENT_NOEXEC+1], sel[ENT_NOREAD-1:PA_W],
                          sel[FRAME_LSB-1:ENT_STRICT+1],
                          sel[ENT_STRICT-1:ENT_LVL_LO+LVL_W]};

    // Privilege rule: at-most when relaxed, exactly-equal when strict.
    always_comb priv_bad = fl.strict ? (priv != fl.lvl) : (priv > fl.lvl);

    // Fault priority: valid, execute, read, privilege, dirty.
    always_comb begin
        if (!fl.valid)                              code = RES_INVALID;
        else if (acc == ACC_FETCH && fl.no_exec)    code = RES_NOEXEC;
        else if (acc == ACC_LOAD && fl.no_read)     code = RES_NOREAD;
        else if (priv_bad)                          code = RES_PRIV;
        else if (acc == ACC_STORE && !fl.dirty)     code = RES_DIRTY;
        else                                        code = RES_OK;
    end

    // Offset mask covering the bits below the page-size position.
    always_comb off_mask = ~({XLEN{1'b1}} << page_shift);

    // Frame address with the in-page offset merged in.
    always_comb pa = {frame, {FRAME_LSB{1'b0}}} | (vaddr[PA_W-1:0] & off_mask[PA_W-1:0]);

    // Rights granted by the chosen half.
    always_comb begin
        r = 1'b1;
        w = fl.dirty;
        x = !fl.no_exec;
    end

    // R6: a cleared valid bit always yields the invalid code
    a_r6_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
        !fl.valid |-> code == RES_INVALID);

    // R10: a store can only pass the entry checks on a dirty page
    a_r10_store_needs_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_STORE && code == RES_OK) |-> fl.dirty);

    // R9: a strict entry passes only at its own level
    a_r9_strict_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (code == RES_OK && fl.strict) |-> priv == fl.lvl);

    // R7: a fetch that passes never targets a no-execute page
    a_r7_fetch_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_FETCH && code == RES_OK) |-> x);

    // R11: the in-page offset bits of the address follow the virtual address
    a_r11_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((pa ^ vaddr[PA_W-1:0]) & off_mask[PA_W-1:0] & ~{frame, {FRAME_LSB{1'b0}}}) == '0);

endmodule

// File: rtl/page_xlat_checker.sv
// Module: page_xlat_checker
// Top of the translation checker. Chooses among direct addressing, the
// direct-map windows, the canonical-address test and the paged entry
// checks, then drives the address, rights and result code.
// Assumes PA_W <= VA_W, acc never 3, and 12 <= page_shift < PA_W.
// clk and rst_n only sample the embedded property checks.
module page_xlat_checker
    import xlat_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int VA_W  = 48,
    parameter int PA_W  = 48,
    parameter int NWIN  = 4,
    localparam int EXT_W = XLEN - VA_W,
    localparam int SH_W  = $clog2(XLEN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [XLEN-1:0]      vaddr,
    input  logic [1:0]           acc,
    input  logic [LVL_W-1:0]     priv,
    input  logic                 direct_en,
    input  logic                 paging_en,
    input  logic [NWIN*XLEN-1:0] win_cfg,
    input  logic [SH_W-1:0]      page_shift,
    input  logic                 hit,
    input  logic [XLEN-1:0]      entry_even,
    input  logic [XLEN-1:0]      entry_odd,
    output logic [PA_W-1:0]      paddr,
    output logic                 perm_r,
    output logic                 perm_w,
    output logic                 perm_x,
    output logic [2:0]           result
);

    localparam int NLVL = 1 << LVL_W;

    logic [NWIN-1:0]  win_hit;
    logic [NWIN-1:0]  win_first;
    logic             any_win;
    logic             canon_ok;
    logic             direct_mode;
    logic [XLEN-1:0]  stripped;
    xlat_res_e        pg_code;
    logic [PA_W-1:0]  pg_pa;
    logic             pg_r, pg_w, pg_x;
    xlat_res_e        res;

    // One window comparator per window word.
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        xlat_window_match #(
            .XLEN(XLEN), .VA_W(VA_W), .NLVL(NLVL)
        ) u_win (
            .win_word (win_cfg[g*XLEN +: XLEN]),
            .va_upper (vaddr[XLEN-1:VA_W]),
            .priv     (priv),
            .match    (win_hit[g])
        );
    end

    // Lowest-numbered matching window takes the access.
    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < NWIN; i++) begin
            win_first[i] = win_hit[i] && !seen;
            seen         = seen || win_hit[i];
        end
        any_win = seen;
    end

    xlat_canon_check #(
        .XLEN(XLEN), .VA_W(VA_W), .EXT_W(EXT_W)
    ) u_canon (
        .vaddr    (vaddr),
        .canon_ok (canon_ok)
    );

    xlat_page_check #(
        .XLEN(XLEN), .PA_W(PA_W)
    ) u_page (
        .clk        (clk),
        .rst_n      (rst_n),
        .vaddr      (vaddr),
        .acc        (acc),
        .priv       (priv),
        .page_shift (page_shift),
        .entry_even (entry_even),
        .entry_odd  (entry_odd),
        .code       (pg_code),
        .pa         (pg_pa),
        .r          (pg_r),
        .w          (pg_w),
        .x          (pg_x)
    );

    // Direct addressing applies only with paging switched off.
    always_comb direct_mode = direct_en && !paging_en;

    // Window address: drop the base bits above the virtual space.
    always_comb stripped = vaddr & {{EXT_W{1'b0}}, {VA_W{1'b1}}};

    // Final selection of address, rights and code by mode priority.
    always_comb begin
        paddr  = '0;
        perm_r = 1'b0;
        perm_w = 1'b0;
        perm_x = 1'b0;
        if (direct_mode) begin
            res    = RES_OK;
            paddr  = vaddr[PA_W-1:0];
            perm_r = 1'b1;
            perm_w = 1'b1;
            perm_x = 1'b1;
        end else if (any_win) begin
            res    = RES_OK;
            paddr  = stripped[PA_W-1:0];
            perm_r = 1'b1;
            perm_w = 1'b1;
            perm_x = 1'b1;
        end else if (!canon_ok) begin
            res = RES_BADADDR;
        end else if (!hit) begin
            res = RES_MISS;
        end else begin
            res = pg_code;
            if (pg_code == RES_OK) begin
                paddr  = pg_pa;
                perm_r = pg_r;
                perm_w = pg_w;
                perm_x = pg_x;
            end
        end
        result = res;
    end

    // R1: direct mode passes the address through with every right
    a_r1_direct_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_en && !paging_en) |->
            (result == RES_OK && paddr == vaddr[PA_W-1:0] && {perm_r, perm_w, perm_x} == 3'b111));

    // R2: at most one window is chosen
    a_r2_one_window: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_first));

    // R2: a window claim grants every right
    a_r2_window_rights: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct_mode && |win_hit) |-> (result == RES_OK && {perm_r, perm_w, perm_x} == 3'b111));

    // R3: a non-canonical address outside any window is a bad address
    a_r3_noncanon: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct_mode && win_hit == '0 && !canon_ok) |-> result == RES_BADADDR);

    // R4: a canonical miss reports no match
    a_r4_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct_mode && win_hit == '0 && canon_ok && !hit) |-> result == RES_MISS);

    // R13: any fault clears the address and rights
    a_r13_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (result != RES_OK) |-> (paddr == '0 && {perm_r, perm_w, perm_x} == 3'b000));

    // R12: a paged pass always grants read
    a_r12_read_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (result == RES_OK) |-> perm_r);

endmodule

// File: tb/page_xlat_checker_bench.sv
// Directed bench for the translation checker: one task per scenario.
module page_xlat_checker_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  vaddr = '0;
    logic [1:0]   acc = 2'd1;
    logic [1:0]   priv = 2'd0;
    logic         direct_en = 1'b0;
    logic         paging_en = 1'b0;
    logic [255:0] win_cfg = '0;
    logic [5:0]   page_shift = 6'd14;
    logic         hit = 1'b0;
    logic [63:0]  entry_even = '0;
    logic [63:0]  entry_odd = '0;
    logic [47:0]  paddr;
    logic         perm_r, perm_w, perm_x;
    logic [2:0]   result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [63:0] F_V   = 64'h1;
    localparam logic [63:0] F_D   = 64'h2;
    localparam logic [63:0] F_STR = 64'h80;
    localparam logic [63:0] F_NR  = 64'h2000_0000_0000_0000;
    localparam logic [63:0] F_NX  = 64'h4000_0000_0000_0000;

    always #10 clk = ~clk;

    page_xlat_checker u_page_xlat_checker (
        .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .acc(acc), .priv(priv),
        .direct_en(direct_en), .paging_en(paging_en), .win_cfg(win_cfg),
        .page_shift(page_shift), .hit(hit), .entry_even(entry_even),
        .entry_odd(entry_odd), .paddr(paddr), .perm_r(perm_r),
        .perm_w(perm_w), .perm_x(perm_x), .result(result)
    );

    function automatic logic [63:0] lvl(input int l);
        return 64'(l) << 2;
    endfunction

    task automatic settle();
        #5;
    endtask

    task automatic chk(input string tag, input logic [2:0] ec,
                       input logic [47:0] epa, input logic [2:0] erwx);
        n_checks++;
        if (result !== ec || paddr !== epa || {perm_r, perm_w, perm_x} !== erwx) begin
            n_fail++;
            $display("FAIL %s: got code=%0d pa=%h rwx=%b, expected code=%0d pa=%h rwx=%b",
                     tag, result, paddr, {perm_r, perm_w, perm_x}, ec, epa, erwx);
        end
    endtask

    task automatic clear_inputs();
        @(negedge clk);
        vaddr = '0; acc = 2'd1; priv = 2'd0; direct_en = 1'b0; paging_en = 1'b1;
        win_cfg = '0; page_shift = 6'd14; hit = 1'b0;
        entry_even = '0; entry_odd = '0;
    endtask

    // R4 R13: idle inputs give a quiet miss
    task automatic t_reset_state();
        @(negedge clk); settle();
        chk("R4/R13 reset idle miss", 3'd2, 48'h0, 3'b000);
    endtask

    // R1: direct mode beats windows, a miss and a bad extension
    task automatic t_direct();
        clear_inputs();
        direct_en = 1'b1; paging_en = 1'b0; vaddr = 64'hFFF0_1234_5678_9ABC;
        win_cfg[63:0] = {16'hFFF0, 44'h0, 4'hF}; settle();
        chk("R1 direct pass-through", 3'd0, 48'h1234_5678_9ABC, 3'b111);
        @(negedge clk); paging_en = 1'b1; win_cfg = '0; settle();
        chk("R1 R3 direct bit ignored when paging on", 3'd1, 48'h0, 3'b000);
    endtask

    // R2: window enables per level and base compare
    task automatic t_windows();
        clear_inputs();
        win_cfg[63:0]    = {16'h9000, 44'h0, 4'b0001};
        win_cfg[191:128] = {16'h8000, 44'h0, 4'b1000};
        vaddr = 64'h9000_0000_0040_1000; priv = 2'd0; settle();
        chk("R2 window0 level0", 3'd0, 48'h0000_0040_1000, 3'b111);
        @(negedge clk); priv = 2'd3; hit = 1'b1; entry_even = F_V | F_D | lvl(3); settle();
        chk("R2 R3 window0 disabled at level3", 3'd1, 48'h0, 3'b000);
        @(negedge clk); vaddr = 64'h8000_0012_3456_7000; settle();
        chk("R2 window2 level3", 3'd0, 48'h0012_3456_7000, 3'b111);
        @(negedge clk); paging_en = 1'b0; settle();
        chk("R2 window with paging off", 3'd0, 48'h0012_3456_7000, 3'b111);
    endtask

    // R3 R4: canonical test and miss
    task automatic t_canon_miss();
        clear_inputs();
        vaddr = 64'hFFFF_8000_0000_0000; hit = 1'b0; settle();
        chk("R4 canonical high miss", 3'd2, 48'h0, 3'b000);
        @(negedge clk); vaddr = 64'h0001_0000_0000_0000; hit = 1'b1;
        entry_even = F_V | F_D; settle();
        chk("R3 bad extension with hit", 3'd1, 48'h0, 3'b000);
    endtask

    // R5 R11 R12: even/odd selection and address forming
    task automatic t_select();
        clear_inputs();
        hit = 1'b1;
        entry_even = 64'h0000_0012_3450_0000 | F_V | F_D;
        entry_odd  = 64'h0000_0000_0777_0000 | F_V;
        vaddr = 64'h0000_0000_1000_2ABC; settle();
        chk("R5 R11 R12 even half", 3'd0, 48'h0012_3450_2ABC, 3'b111);
        @(negedge clk); vaddr = 64'h0000_0000_1000_6ABC; settle();
        chk("R5 R12 odd half clean page", 3'd0, 48'h0000_0777_2ABC, 3'b101);
        @(negedge clk); page_shift = 6'd21;
        entry_even = 64'h0000_0000_4000_0000 | F_V | F_D | F_NX;
        vaddr = 64'h0000_0000_001A_BCDE; settle();
        chk("R11 R12 large page offset", 3'd0, 48'h0000_401A_BCDE, 3'b110);
        @(negedge clk); page_shift = 6'd12; entry_odd = 64'h0000_0000_0055_5000 | F_V | F_D;
        vaddr = 64'h0000_0000_0000_1FFF; settle();
        chk("R5 R11 smallest page odd", 3'd0, 48'h0000_0055_5FFF, 3'b111);
    endtask

    // R6 R7 R8 R9 R10: fault priority
    task automatic t_faults();
        clear_inputs();
        hit = 1'b1; vaddr = 64'h0000_0000_0000_0100; priv = 2'd2;
        entry_even = F_NX | F_NR | lvl(0); acc = 2'd0; settle();
        chk("R6 invalid beats all", 3'd3, 48'h0, 3'b000);
        @(negedge clk); entry_even = F_V | F_NX | F_NR | lvl(0); settle();
        chk("R7 no-execute before privilege", 3'd6, 48'h0, 3'b000);
        @(negedge clk); acc = 2'd1; settle();
        chk("R8 no-read before privilege", 3'd5, 48'h0, 3'b000);
        @(negedge clk); acc = 2'd0; entry_even = F_V | F_D | F_NR | lvl(3); settle();
        chk("R8 no-read ignored on fetch", 3'd0, 48'h0000_0000_0000_0100, 3'b111);
        @(negedge clk); acc = 2'd2; entry_even = F_V | lvl(1); settle();
        chk("R9 privilege before dirty", 3'd7, 48'h0, 3'b000);
        @(negedge clk); priv = 2'd0; settle();
        chk("R10 store to clean page", 3'd4, 48'h0, 3'b000);
        @(negedge clk); entry_even = F_V | F_D | lvl(1); settle();
        chk("R9 relaxed lower level passes", 3'd0, 48'h0000_0000_0000_0100, 3'b111);
        @(negedge clk); entry_even = F_V | F_D | F_STR | lvl(1); settle();
        chk("R9 strict rejects lower level", 3'd7, 48'h0, 3'b000);
        @(negedge clk); priv = 2'd1; settle();
        chk("R9 strict equal passes", 3'd0, 48'h0000_0000_0000_0100, 3'b111);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset_state();
        @(negedge clk); rst_n = 1'b1;
        t_direct();
        t_windows();
        t_canon_miss();
        t_select();
        t_faults();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule